// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block is the hazard control unit of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It watches a small set of control and register-number signals taken from the decode and execute pipeline registers. From them it produces the enables, bubble select, squash lines and next-PC source select that the datapath applies. It contains no datapath of its own.

It resolves three situations. The first is a load-use dependency: a load sitting in the execute-side register whose destination is a source of the instruction in decode. The unit holds the PC and the fetch/decode register for one cycle and tells the datapath to zero the control word entering execute. The second is a branch resolved as taken in decode. Fetch defaults to sequential (predict not-taken), so only the one wrongly fetched instruction in the fetch/decode register is squashed and the PC takes the branch target. The third is an arithmetic overflow raised in execute. The faulting instruction and everything younger are squashed, the PC is steered to a fixed trap vector, and the faulting instruction's address is latched into an exception PC register.

Overflow outranks a taken branch, and any redirect outranks a stall. All outputs except the exception PC are combinational in the current inputs, so they act in the same cycle. All signals are plain control pins with no handshake.

Top module: `hazard_ctrl`

## Requirements
- R1: When `ld_in_ex` is 1 and `ex_dst` equals `dec_src_a` or `dec_src_b`, and neither `br_taken` nor `ovf` is 1, the unit stalls: `pc_we`=0, `ifid_we`=0, `bubble_sel`=1.
- R2: When there is no load-use match (`ld_in_ex`=0, or `ex_dst` matches neither decode source) and no redirect, `pc_we`=1, `ifid_we`=1, `bubble_sel`=0, all three flush outputs are 0 and `pc_src`=2'b00 (sequential).
- R3: A taken branch (`br_taken`=1, `ovf`=0) drives `flush_ifid`=1, `flush_id`=0, `flush_ex`=0 and `pc_src`=2'b01 (branch target).
- R4: An overflow (`ovf`=1) drives `flush_ifid`=1, `flush_id`=1, `flush_ex`=1 and `pc_src`=2'b10 (trap vector).
- R5: `trap_pc` always presents the parameter `TRAP_VEC`, whose default is 32'h4000_0040. This is the address that `pc_src`=2'b10 selects.
- R6: When `ovf` and `br_taken` are both 1, the overflow outcome of R4 applies and the branch is ignored (`pc_src`=2'b10).
- R7: When a redirect (`ovf` or `br_taken`) coincides with a load-use match, no stall occurs: `pc_we`=1, `ifid_we`=1, `bubble_sel`=0.
- R8: On a clock edge with `ovf`=1, `epc` loads `ex_pc`. On every other edge `epc` keeps its value.
- R9: While `rst_n` is 0, `epc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_in_ex | input | 1 | Instruction in the execute-side register reads memory |
| ex_dst | input | REG_W | Destination register number of that instruction |
| dec_src_a | input | REG_W | First source register of the instruction in decode |
| dec_src_b | input | REG_W | Second source register of the instruction in decode |
| br_taken | input | 1 | Branch in decode resolved as taken |
| ovf | input | 1 | Arithmetic overflow raised in execute |
| ex_pc | input | ADDR_W | Address of the instruction in execute |
| pc_we | output | 1 | PC register write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| bubble_sel | output | 1 | Select all-zero control word into execute |
| flush_ifid | output | 1 | Squash the fetch/decode register |
| flush_id | output | 1 | Zero the controls of the decode-stage instruction |
| flush_ex | output | 1 | Zero the controls of the execute-stage instruction |
| pc_src | output | 2 | Next PC: 00 sequential, 01 branch target, 10 trap vector |
| trap_pc | output | ADDR_W | Trap vector address |
| epc | output | ADDR_W | Address of the last instruction that overflowed |

## Verification
The bench builds the unit with REG_W=3, ADDR_W=16 and TRAP_VEC=16'h4040. The three-bit register numbers make random load-use matches frequent, and that brings every overlap of stall, branch and overflow within reach in a few thousand cycles. The short address keeps the exception PC comparison readable. Directed cycles cover each register-match case on its own and the priority corners. A long random run is then compared against a behavioural model on every clock.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  typedef enum logic [1:0] {
    PCS_SEQ    = 2'b00,
    PCS_BRANCH = 2'b01,
    PCS_TRAP   = 2'b10
  } pc_src_e;
endpackage

// File: rtl/hzc_loaduse.sv
module hzc_loaduse #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic                        ld_flag,
  input  logic [REG_W-1:0]            ld_dst,
  input  logic [NSRC-1:0][REG_W-1:0]  srcs,
  output logic                        hit
);
  logic [NSRC-1:0] match;

  // One comparator per decode source operand.
  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    assign match[g] = (srcs[g] == ld_dst);
  end

  assign hit = ld_flag && (|match);
endmodule

// File: rtl/hzc_redirect.sv
module hzc_redirect
  import hzc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load_hit,
  input  logic    br_taken,
  input  logic    ovf,
  output logic    pc_we,
  output logic    ifid_we,
  output logic    bubble_sel,
  output logic    flush_ifid,
  output logic    flush_id,
  output logic    flush_ex,
  output pc_src_e pc_src
);
  logic redirect;
  logic stall;

  assign redirect = ovf || br_taken;
  assign stall    = load_hit && !redirect;

  always_comb begin
    pc_src     = PCS_SEQ;
    flush_ifid = 1'b0;
    flush_id   = 1'b0;
    flush_ex   = 1'b0;
    if (ovf) begin
      pc_src     = PCS_TRAP;
      flush_ifid = 1'b1;
      flush_id   = 1'b1;
      flush_ex   = 1'b1;
    end else if (br_taken) begin
      pc_src     = PCS_BRANCH;
      flush_ifid = 1'b1;
    end
  end

  assign pc_we      = !stall;
  assign ifid_we    = !stall;
  assign bubble_sel = stall;

  // R6: overflow wins over a simultaneous branch
  assert_trap_over_branch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && br_taken) |-> (pc_src == PCS_TRAP && flush_ex));

  // R7: a redirect never coexists with a stall
  assert_flush_beats_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && load_hit) |-> (pc_we && ifid_we && !bubble_sel));

  // R3: branch squashes only the fetch/decode register
  assert_branch_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken && !ovf) |-> (flush_ifid && !flush_id && !flush_ex));
endmodule

// File: rtl/hzc_epc.sv
module hzc_epc #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] pc_in,
  output logic [ADDR_W-1:0] epc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       epc <= '0;
    else if (capture) epc <= pc_in;
  end

  // R8: capture on overflow, hold otherwise
  assert_epc_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (epc == $past(pc_in)));
  assert_epc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(epc));
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hzc_pkg::*;
#(
  parameter int              REG_W    = 5,
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] TRAP_VEC = ADDR_W'(32'h4000_0040)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_in_ex,
  input  logic [REG_W-1:0]  ex_dst,
  input  logic [REG_W-1:0]  dec_src_a,
  input  logic [REG_W-1:0]  dec_src_b,
  input  logic              br_taken,
  input  logic              ovf,
  input  logic [ADDR_W-1:0] ex_pc,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              bubble_sel,
  output logic              flush_ifid,
  output logic              flush_id,
  output logic              flush_ex,
  output logic [1:0]        pc_src,
  output logic [ADDR_W-1:0] trap_pc,
  output logic [ADDR_W-1:0] epc
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_W-1:0] srcs;
  logic                       load_hit;
  pc_src_e                    src_sel;

  assign srcs[0] = dec_src_a;
  assign srcs[1] = dec_src_b;

  hzc_loaduse #(.REG_W(REG_W), .NSRC(NSRC)) u_loaduse (
    .ld_flag (ld_in_ex),
    .ld_dst  (ex_dst),
    .srcs    (srcs),
    .hit     (load_hit)
  );

  hzc_redirect u_redirect (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_hit   (load_hit),
    .br_taken   (br_taken),
    .ovf        (ovf),
    .pc_we      (pc_we),
    .ifid_we    (ifid_we),
    .bubble_sel (bubble_sel),
    .flush_ifid (flush_ifid),
    .flush_id   (flush_id),
    .flush_ex   (flush_ex),
    .pc_src     (src_sel)
  );

  hzc_epc #(.ADDR_W(ADDR_W)) u_epc (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (ovf),
    .pc_in   (ex_pc),
    .epc     (epc)
  );

  assign pc_src  = src_sel;
  assign trap_pc = TRAP_VEC;

  // R1: a load-use match with no redirect freezes fetch and decode
  assert_loaduse_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_in_ex && (ex_dst == dec_src_a || ex_dst == dec_src_b) && !br_taken && !ovf)
      |-> (!pc_we && !ifid_we && bubble_sel));

  // R2: no load and no redirect means free flow
  assert_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_in_ex && !br_taken && !ovf)
      |-> (pc_we && ifid_we && !bubble_sel && pc_src == 2'b00 && !flush_ifid));

  // R4: overflow squashes three stages and vectors to the trap
  assert_ovf_squash_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (flush_ifid && flush_id && flush_ex && pc_src == 2'b10));
endmodule

// File: tb/hazard_ctrl_tb.sv
module hazard_ctrl_tb;
  localparam int REG_W = 3;
  localparam int ADDR_W = 16;
  localparam logic [ADDR_W-1:0] TRAP = 16'h4040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_in_ex = 1'b0, br_taken = 1'b0, ovf = 1'b0;
  logic [REG_W-1:0] ex_dst = '0, dec_src_a = '0, dec_src_b = '0;
  logic [ADDR_W-1:0] ex_pc = '0;
  logic pc_we, ifid_we, bubble_sel, flush_ifid, flush_id, flush_ex;
  logic [1:0] pc_src;
  logic [ADDR_W-1:0] trap_pc, epc;

  int n_chk = 0, n_bad = 0;
  logic [ADDR_W-1:0] m_epc = '0;
  bit done = 0;

  always #4 clk = ~clk;

  hazard_ctrl #(.REG_W(REG_W), .ADDR_W(ADDR_W), .TRAP_VEC(TRAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_in_ex(ld_in_ex), .ex_dst(ex_dst),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .br_taken(br_taken),
    .ovf(ovf), .ex_pc(ex_pc), .pc_we(pc_we), .ifid_we(ifid_we),
    .bubble_sel(bubble_sel), .flush_ifid(flush_ifid), .flush_id(flush_id),
    .flush_ex(flush_ex), .pc_src(pc_src), .trap_pc(trap_pc), .epc(epc)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural model of the requirements, compared in the low clock phase.
  task automatic compare();
    bit lu, stall;
    string rq;
    lu = ld_in_ex && (ex_dst == dec_src_a || ex_dst == dec_src_b);
    stall = lu && !ovf && !br_taken;
    rq = ovf ? (br_taken ? "R6" : "R4") : (br_taken ? "R3" : (lu ? "R1" : "R2"));
    if (lu && (ovf || br_taken)) rq = "R7";
    chk(rq, "pc_we", 32'(pc_we), 32'(!stall));
    chk(rq, "ifid_we", 32'(ifid_we), 32'(!stall));
    chk(rq, "bubble_sel", 32'(bubble_sel), 32'(stall));
    chk(rq, "flush_ifid", 32'(flush_ifid), 32'(ovf || br_taken));
    chk(rq, "flush_id", 32'(flush_id), 32'(ovf));
    chk(rq, "flush_ex", 32'(flush_ex), 32'(ovf));
    chk(rq, "pc_src", 32'(pc_src), ovf ? 32'd2 : (br_taken ? 32'd1 : 32'd0));
    chk("R5", "trap_pc", 32'(trap_pc), 32'(TRAP));
    chk("R8", "epc", 32'(epc), 32'(m_epc));
  endtask

  task automatic step(bit l, int d, int a, int b, bit br, bit ov, int pc);
    @(negedge clk);
    ld_in_ex = l; ex_dst = REG_W'(d); dec_src_a = REG_W'(a); dec_src_b = REG_W'(b);
    br_taken = br; ovf = ov; ex_pc = ADDR_W'(pc);
    #2;
    compare();
    @(posedge clk);
    if (ov) m_epc = ADDR_W'(pc);
  endtask

  initial begin
    #3;
    chk("R9", "epc in reset", 32'(epc), 32'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9", "epc after reset", 32'(epc), 32'd0);
    rst_n = 1'b1;
    // R2: free flow, load without match, match without load
    step(0, 3, 1, 2, 0, 0, 16'h0100);
    step(1, 3, 1, 2, 0, 0, 16'h0104);
    step(0, 3, 3, 3, 0, 0, 16'h0108);
    // R1: match on first source, second source, both
    step(1, 5, 5, 2, 0, 0, 16'h010c);
    step(1, 6, 1, 6, 0, 0, 16'h0110);
    step(1, 0, 0, 0, 0, 0, 16'h0114);
    // R3 taken branch
    step(0, 1, 2, 3, 1, 0, 16'h0118);
    // R4 / R8 overflow captures the pc
    step(0, 1, 2, 3, 0, 1, 16'h011c);
    step(0, 1, 2, 3, 0, 0, 16'h0120);
    // R6 overflow with branch
    step(0, 1, 2, 3, 1, 1, 16'h0124);
    // R7 redirects with a load-use match
    step(1, 4, 4, 0, 1, 0, 16'h0128);
    step(1, 4, 0, 4, 0, 1, 16'h012c);
    step(1, 4, 4, 4, 1, 1, 16'h0130);
    // random run against the model
    for (int i = 0; i < 4000; i++) begin
      step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
           int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
           $urandom_range(0, 3) == 0, $urandom_range(0, 5) == 0,
           int'($urandom_range(0, 65535)));
    end
    done = 1;
  end

  initial begin
    fork
      begin : wd
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      wait (done);
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule